// File: doc/BRIEF.md
# Restore Precondition Fault Checker

This block decides, before any architectural state is touched, whether an extended-state restore instruction may proceed. On a check request it captures the decoded prefix flags, the feature-supported bit, the OS-enable and task-switched control bits, the source effective address, the feature-enable mask, the saved-component bitmap and reserved words of the in-memory header, and the image value destined for the vector control/status register. One cycle later it reports either "no fault" or exactly one fault class.

Fault classes are prioritised. Opcode-level problems (missing feature support, OS enable cleared, LOCK or operand-size/repeat prefixes) give invalid opcode. Otherwise a set task-switched bit gives device-not-available. Otherwise any data-dependent problem gives general protection with error code 0: a misaligned source, a saved component that is not enabled, non-zero reserved header bytes, or a reserved bit set in the vector control/status image. The floating-point stack component has no reserved-bit check. Page, segment-limit and canonical-address faults are computed elsewhere. The restore mask plays no part in any fault decision, so its upper halves, which are ignored in 64-bit mode, never reach this block.

Top module: `restore_fault_checker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `rslt_vld_o` and `fault_vld_o` are 0 and `fault_cls_o` is 2'b00.
- R2: `rslt_vld_o` is 1 in exactly the cycle after a clock edge that samples `chk_req_i` high, and 0 otherwise; `fault_vld_o` is 0 and `fault_cls_o` is 2'b00 whenever `rslt_vld_o` is 0.
- R3: Invalid opcode (class 2'b01) is reported when `feat_sup_i` is 0, `os_en_i` is 0, `pfx_lock_i` is 1, or any of `pfx_opsz_i`, `pfx_rep_i`, `pfx_repne_i` is 1.
- R4: Device-not-available (class 2'b10) is reported when `task_sw_i` is 1 and no invalid-opcode condition holds.
- R5: General protection (class 2'b11) is reported when address bits [5:0] are not all zero.
- R6: General protection is reported when any bitmap bit in positions 62..0 is 1 while the same bit of `feat_en_i` is 0; bit 63 of both is ignored.
- R7: General protection is reported when any bit of the 128-bit reserved header field (header bytes 8 through 23) is 1.
- R8: General protection is reported when `vcsr_img_i` has a 1 in a reserved position; by default bits 31..16 are reserved and bits 15..0 are free.
- R9: Only the highest-priority fault is reported: invalid opcode over device-not-available over general protection.
- R10: A request with no fault condition gives `rslt_vld_o`=1, `fault_vld_o`=0 and class 2'b00.
- R11: Inputs are sampled only on a request edge; changes while `chk_req_i` is 0 do not alter the pending result.
- R12: Requests on consecutive cycles each produce their own result on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_req_i | input | 1 | Check request strobe |
| pfx_lock_i | input | 1 | LOCK prefix present |
| pfx_opsz_i | input | 1 | Operand-size (66h) prefix present |
| pfx_rep_i | input | 1 | F3h prefix present |
| pfx_repne_i | input | 1 | F2h prefix present |
| feat_sup_i | input | 1 | Extended-state save/restore supported |
| os_en_i | input | 1 | OS-enable control bit (control register 4, bit 18) |
| task_sw_i | input | 1 | Task-switched bit (control register 0, bit 3) |
| src_addr_i | input | 64 | Source effective address |
| feat_en_i | input | 64 | Feature-enable mask |
| hdr_bitmap_i | input | 64 | Saved-component bitmap from the header |
| hdr_rsv_i | input | 128 | Header bytes 8 through 23 |
| vcsr_img_i | input | 32 | Image value for the vector control/status register |
| rslt_vld_o | output | 1 | Result valid |
| fault_vld_o | output | 1 | A fault is reported |
| fault_cls_o | output | 2 | 00 none, 01 invalid opcode, 10 device-not-available, 11 general protection |

## Verification
The assertions take for granted that every input is stable and known at the clock edge where `chk_req_i` is high, and that `rst_n` is released away from a request; they relate a result only to the inputs sampled one edge earlier. The stimulus drives all inputs together with the request on the falling edge, holds no request across reset release, and deliberately scrambles inputs on idle cycles so that any sampling outside a request edge would show at the outputs.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
  typedef enum logic [1:0] {
    FC_NONE = 2'b00,
    FC_UD   = 2'b01,
    FC_NM   = 2'b10,
    FC_GP   = 2'b11
  } fault_cls_t;
endpackage

// File: rtl/rfc_cap_reg.sv
module rfc_cap_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] nxt;

  always_comb begin
    nxt = q_o;
    if (en_i) nxt = d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= nxt;
  end
endmodule

// File: rtl/rfc_opcode_chk.sv
module rfc_opcode_chk (
  input  logic lock_i,
  input  logic opsz_i,
  input  logic rep_i,
  input  logic repne_i,
  input  logic sup_i,
  input  logic osen_i,
  input  logic ts_i,
  output logic ud_o,
  output logic nm_o
);
  logic bad_pfx;

  always_comb begin
    bad_pfx = lock_i | opsz_i | rep_i | repne_i;
    ud_o    = ~sup_i | ~osen_i | bad_pfx;
    nm_o    = ts_i;
  end
endmodule

// File: rtl/rfc_image_chk.sv
module rfc_image_chk #(
  parameter int          ADDR_W     = 64,
  parameter int          ALIGN_LOG2 = 6,
  parameter int          FEAT_W     = 64,
  parameter int          FEAT_CHK_W = 63,
  parameter int          HDR_RSV_W  = 128,
  parameter int          VCSR_W     = 32,
  parameter logic [31:0] VCSR_RSV   = 32'hFFFF_0000
) (
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [FEAT_W-1:0]    en_i,
  input  logic [FEAT_W-1:0]    bm_i,
  input  logic [HDR_RSV_W-1:0] hdr_i,
  input  logic [VCSR_W-1:0]    vcsr_i,
  output logic                 gp_o
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ADDR_W'((64'd1 << ALIGN_LOG2) - 64'd1);
  localparam logic [FEAT_W-1:0] CHK_MASK   = {FEAT_W{1'b1}} >> (FEAT_W - FEAT_CHK_W);
  localparam logic [VCSR_W-1:0] RSV_MASK   = VCSR_RSV[VCSR_W-1:0];
  localparam int                HDR_WORDS  = (HDR_RSV_W + 31) / 32;
  localparam int                HDR_PAD_W  = HDR_WORDS * 32;

  logic [HDR_PAD_W-1:0] hdr_pad;
  logic [HDR_WORDS-1:0] word_nz;
  logic                 misalign;
  logic                 feat_bad;
  logic                 vcsr_bad;

  assign hdr_pad = HDR_PAD_W'(hdr_i);

  genvar gw;
  generate
    for (gw = 0; gw < HDR_WORDS; gw++) begin : g_hdr_word
      assign word_nz[gw] = |hdr_pad[gw*32 +: 32];
    end
  endgenerate

  always_comb begin
    misalign = |(addr_i & ALIGN_MASK);
    feat_bad = |(bm_i & ~en_i & CHK_MASK);
    vcsr_bad = |(vcsr_i & RSV_MASK);
    gp_o     = misalign | feat_bad | (|word_nz) | vcsr_bad;
  end
endmodule

// File: rtl/rfc_prio.sv
module rfc_prio
  import rfc_pkg::*;
(
  input  logic       vld_i,
  input  logic       ud_i,
  input  logic       nm_i,
  input  logic       gp_i,
  output logic       fault_o,
  output logic [1:0] cls_o
);
  fault_cls_t cls;

  always_comb begin
    cls = FC_NONE;
    if (vld_i) begin
      if (ud_i)      cls = FC_UD;
      else if (nm_i) cls = FC_NM;
      else if (gp_i) cls = FC_GP;
    end
    cls_o   = cls;
    fault_o = (cls != FC_NONE);
  end
endmodule

// File: rtl/restore_fault_checker.sv
module restore_fault_checker
  import rfc_pkg::*;
#(
  parameter int          ADDR_W     = 64,
  parameter int          ALIGN_LOG2 = 6,
  parameter int          FEAT_W     = 64,
  parameter int          FEAT_CHK_W = 63,
  parameter int          HDR_RSV_W  = 128,
  parameter int          VCSR_W     = 32,
  parameter logic [31:0] VCSR_RSV   = 32'hFFFF_0000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 chk_req_i,
  input  logic                 pfx_lock_i,
  input  logic                 pfx_opsz_i,
  input  logic                 pfx_rep_i,
  input  logic                 pfx_repne_i,
  input  logic                 feat_sup_i,
  input  logic                 os_en_i,
  input  logic                 task_sw_i,
  input  logic [ADDR_W-1:0]    src_addr_i,
  input  logic [FEAT_W-1:0]    feat_en_i,
  input  logic [FEAT_W-1:0]    hdr_bitmap_i,
  input  logic [HDR_RSV_W-1:0] hdr_rsv_i,
  input  logic [VCSR_W-1:0]    vcsr_img_i,
  output logic                 rslt_vld_o,
  output logic                 fault_vld_o,
  output logic [1:0]           fault_cls_o
);
  localparam int CTL_W = 7;
  localparam int CAP_W = CTL_W + ADDR_W + 2*FEAT_W + HDR_RSV_W + VCSR_W;

  logic [CAP_W-1:0]     cap_d, cap_q;
  logic [CTL_W-1:0]     ctl_q;
  logic [ADDR_W-1:0]    addr_q;
  logic [FEAT_W-1:0]    en_q, bm_q;
  logic [HDR_RSV_W-1:0] hdr_q;
  logic [VCSR_W-1:0]    vcsr_q;
  logic                 vld_d, vld_q;
  logic                 ud, nm, gp;

  assign cap_d = {pfx_lock_i, pfx_opsz_i, pfx_rep_i, pfx_repne_i, feat_sup_i,
                  os_en_i, task_sw_i, src_addr_i, feat_en_i, hdr_bitmap_i,
                  hdr_rsv_i, vcsr_img_i};
  assign {ctl_q, addr_q, en_q, bm_q, hdr_q, vcsr_q} = cap_q;

  rfc_cap_reg #(.W(CAP_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .en_i(chk_req_i), .d_i(cap_d), .q_o(cap_q)
  );

  always_comb vld_d = chk_req_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  rfc_opcode_chk u_opc (
    .lock_i(ctl_q[6]), .opsz_i(ctl_q[5]), .rep_i(ctl_q[4]), .repne_i(ctl_q[3]),
    .sup_i(ctl_q[2]), .osen_i(ctl_q[1]), .ts_i(ctl_q[0]),
    .ud_o(ud), .nm_o(nm)
  );

  rfc_image_chk #(
    .ADDR_W(ADDR_W), .ALIGN_LOG2(ALIGN_LOG2), .FEAT_W(FEAT_W),
    .FEAT_CHK_W(FEAT_CHK_W), .HDR_RSV_W(HDR_RSV_W), .VCSR_W(VCSR_W),
    .VCSR_RSV(VCSR_RSV)
  ) u_img (
    .addr_i(addr_q), .en_i(en_q), .bm_i(bm_q), .hdr_i(hdr_q), .vcsr_i(vcsr_q),
    .gp_o(gp)
  );

  rfc_prio u_prio (
    .vld_i(vld_q), .ud_i(ud), .nm_i(nm), .gp_i(gp),
    .fault_o(fault_vld_o), .cls_o(fault_cls_o)
  );

  assign rslt_vld_o = vld_q;

  // R2: result strobe follows the request by one edge
  assert_vld_after_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    chk_req_i |=> rslt_vld_o);
  assert_no_vld_wo_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_req_i |=> !rslt_vld_o);
  assert_quiet_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rslt_vld_o |-> (!fault_vld_o && fault_cls_o == 2'b00));
  // R3 / R9: a LOCK prefix always wins
  assert_lock_is_ud_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_req_i && pfx_lock_i) |=> (fault_cls_o == 2'b01));
  // R4 / R9: task-switched with clean opcode gives device-not-available
  assert_ts_is_nm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_req_i && task_sw_i && feat_sup_i && os_en_i && !pfx_lock_i &&
     !pfx_opsz_i && !pfx_rep_i && !pfx_repne_i) |=> (fault_cls_o == 2'b10));
  // R5: misaligned source with no higher fault gives general protection
  assert_misalign_gp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_req_i && !task_sw_i && feat_sup_i && os_en_i && !pfx_lock_i &&
     !pfx_opsz_i && !pfx_rep_i && !pfx_repne_i &&
     (src_addr_i[ALIGN_LOG2-1:0] != '0)) |=> (fault_cls_o == 2'b11));
endmodule

// File: tb/sim_restore_fault_checker.sv
module sim_restore_fault_checker;
  typedef struct packed {
    logic         lock, opsz, rep, repne, sup, osen, ts;
    logic [63:0]  addr, en, bm;
    logic [127:0] hdr;
    logic [31:0]  vcsr;
  } stim_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  stim_t s;
  logic rslt_vld, fault_vld;
  logic [1:0] cls;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [2:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  restore_fault_checker u0 (
    .clk(clk), .rst_n(rst_n), .chk_req_i(req),
    .pfx_lock_i(s.lock), .pfx_opsz_i(s.opsz), .pfx_rep_i(s.rep),
    .pfx_repne_i(s.repne), .feat_sup_i(s.sup), .os_en_i(s.osen),
    .task_sw_i(s.ts), .src_addr_i(s.addr), .feat_en_i(s.en),
    .hdr_bitmap_i(s.bm), .hdr_rsv_i(s.hdr), .vcsr_img_i(s.vcsr),
    .rslt_vld_o(rslt_vld), .fault_vld_o(fault_vld), .fault_cls_o(cls)
  );

  function automatic logic [1:0] expect_cls(stim_t t);
    if (!t.sup || !t.osen || t.lock || t.opsz || t.rep || t.repne) return 2'b01;
    if (t.ts) return 2'b10;
    if (t.addr[5:0] != 6'd0) return 2'b11;
    if ((t.bm & ~t.en & 64'h7FFF_FFFF_FFFF_FFFF) != 64'd0) return 2'b11;
    if (t.hdr != 128'd0) return 2'b11;
    if ((t.vcsr & 32'hFFFF_0000) != 32'd0) return 2'b11;
    return 2'b00;
  endfunction

  function automatic stim_t clean();
    stim_t t;
    t = '0;
    t.sup = 1'b1; t.osen = 1'b1;
    t.addr = 64'h0000_7FFF_1234_5640;
    t.en = 64'h0000_0000_0000_00E7;
    t.bm = 64'h0000_0000_0000_0007;
    t.vcsr = 32'h0000_1F80;
    return t;
  endfunction

  task automatic issue(stim_t t, string tag);
    @(negedge clk);
    s = t;
    req = 1'b1;
    exp_q.push_back({expect_cls(t) != 2'b00, expect_cls(t)});
    tag_q.push_back(tag);
  endtask

  // idle cycle with scrambled inputs (R11: must not be sampled)
  task automatic idle();
    @(negedge clk);
    req = 1'b0;
    s.lock = 1'b1; s.ts = 1'b1; s.addr = 64'h3; s.hdr = '1; s.vcsr = '1;
  endtask

  task automatic check(bit ok, string tag, logic [2:0] act, logic [2:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got vld/cls=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // monitor: scoreboard compare one time unit after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && !done) begin
        if (rslt_vld) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R2 unexpected result", {fault_vld, cls}, 3'b000);
          end else begin
            logic [2:0] e;
            string tg;
            e  = exp_q.pop_front();
            tg = tag_q.pop_front();
            check({fault_vld, cls} == e, tg, {fault_vld, cls}, e);
          end
        end else begin
          check(exp_q.size() == 0 && !fault_vld && cls == 2'b00,
                "R2 idle outputs/missing result", {fault_vld, cls}, 3'b000);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got running expected finished");
    summary();
  end

  initial begin
    stim_t t;
    s = clean();
    #1;
    check(!rslt_vld && !fault_vld && cls == 2'b00, "R1 in reset",
          {fault_vld, cls}, 3'b000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check(!rslt_vld && !fault_vld && cls == 2'b00, "R1 after reset",
          {fault_vld, cls}, 3'b000);

    issue(clean(), "R10 clean request");
    idle();
    t = clean(); t.sup = 1'b0;   issue(t, "R3 unsupported");
    t = clean(); t.osen = 1'b0;  issue(t, "R3 os enable clear");
    t = clean(); t.lock = 1'b1;  issue(t, "R3 lock prefix");
    t = clean(); t.opsz = 1'b1;  issue(t, "R3 66h prefix");
    t = clean(); t.rep = 1'b1;   issue(t, "R3 F3h prefix");
    t = clean(); t.repne = 1'b1; issue(t, "R3 F2h prefix");
    idle();
    t = clean(); t.ts = 1'b1;    issue(t, "R4 task switched");
    t = clean(); t.addr[0] = 1'b1; issue(t, "R5 misaligned by 1");
    t = clean(); t.addr[5] = 1'b1; issue(t, "R5 misaligned by 32");
    t = clean(); t.addr = 64'hFFFF_FFFF_FFFF_FFC0; issue(t, "R5 aligned high address");
    t = clean(); t.bm[3] = 1'b1; issue(t, "R6 component not enabled");
    t = clean(); t.bm[62] = 1'b1; issue(t, "R6 bit 62 not enabled");
    t = clean(); t.bm[63] = 1'b1; issue(t, "R6 bit 63 ignored");
    t = clean(); t.bm = 64'h0000_0000_0000_00E7; issue(t, "R6 bitmap equals enable");
    t = clean(); t.hdr[0] = 1'b1; issue(t, "R7 header low bit");
    t = clean(); t.hdr[127] = 1'b1; issue(t, "R7 header high bit");
    t = clean(); t.vcsr[16] = 1'b1; issue(t, "R8 reserved bit 16");
    t = clean(); t.vcsr[31] = 1'b1; issue(t, "R8 reserved bit 31");
    t = clean(); t.vcsr = 32'h0000_FFFF; issue(t, "R8 free bits only");
    t = clean(); t.lock = 1'b1; t.ts = 1'b1; t.addr[2] = 1'b1; issue(t, "R9 UD over NM and GP");
    t = clean(); t.ts = 1'b1; t.hdr[9] = 1'b1; issue(t, "R9 NM over GP");
    idle();
    idle();
    t = clean(); t.bm[5] = 1'b1; issue(t, "R12 back-to-back first");
    issue(clean(), "R12 back-to-back second");
    idle();
    issue(clean(), "R11 held against idle scramble");
    idle();
    idle();
    @(negedge clk);
    check(exp_q.size() == 0, "R12 all results seen",
          3'(exp_q.size()), 3'b000);
    done = 1;
    summary();
  end
endmodule